// File: doc/BRIEF.md
# Ring-Checked Translation Lookup

This block translates a 32-bit virtual address into a physical address and decides whether the access may proceed. It holds a small set-associative table of translations. Every way is indexed by the four address bits just above that way's page offset. All ways use 4 KiB pages except the last way, which uses 1 MiB pages. Each entry stores a page tag, a physical page number, an 8-bit address-space identifier and a 4-bit attribute code.

Each request carries an address, an access kind and the privilege ring the requester runs at. The kinds are read, write and instruction fetch. One cycle after the request, the block returns the following:
- the physical address;
- the effective rights mask;
- the cache policy;
- a fault cause, which is zero when the access is allowed.

A 32-bit ring map register assigns rings to identifiers. It holds one identifier per byte lane, and the lane number is the ring.

Software loads entries and the ring map through simple write strobes. For a page-table refill engine outside the block, it also provides three values:
- a round-robin refill way;
- the ring field of a fetched page-table word;
- the page-table-entry address of every request.

Top module: `tlb_ring_lookup`

## Requirements
- R1: A way hits when its stored page tag equals the address bits above that way's page offset and its stored identifier is nonzero. The way's entry is chosen by address bits [S+3:S], where S is 12 for ways 0 to 2 and 20 for way 3. Reset clears every identifier to 0, so every lookup after reset misses.
- R2: With no hit, the cause is 24 for read or write and 16 for fetch. The rights, cache code and physical address are all 0.
- R3: With two or more hits, the cause is 25 for read or write and 17 for fetch. The rights, cache code and physical address are all 0.
- R4: The entry's ring is the lowest lane i of the ring map, with lane i at bits [8i+7:8i], whose byte equals the entry's identifier. The ring map resets to 0x04030201. A write to it affects lookups from the next cycle on.
- R5: With exactly one hit, the cause is 26 for read or write and 18 for fetch if either of these holds:
  - the entry's ring is numerically lower than the request ring;
  - no lane of the ring map matches the entry's identifier.
- R6: The rights mask uses bit 0 for read, bit 1 for write and bit 2 for execute. Attributes are decoded as follows:
  - Attribute values below 12 give read, plus write if attribute bit 1 is set, plus execute if attribute bit 0 is set.
  - For those values, attribute bits [3:2] give the cache code: 0 gives 1 (bypass), 1 gives 2 (write-back), 2 gives 3 (write-through).
  - Attribute 13 gives read and write with cache code 4 (isolate).
  - Attributes 12, 14 and 15 give no rights and cache code 0.
- R7: For read and write requests the execute right is removed from the mask. For fetch requests the read and write rights are removed.
- R8: Access kinds are encoded 0 for read, 1 for write and 2 for fetch; 3 is treated as read. If the ring check passes but the masked rights lack the needed right, the cause is 28 for read, 29 for write or 20 for fetch. Miss and multi-hit take priority over the ring check, and the ring check takes priority over rights.
- R9: On a single hit, the physical address is the entry's page address with the bits below the way's page offset taken from the virtual address. This holds whatever the cause.
- R10: All response outputs are registered and appear in the cycle after a request with `req_valid` high. While `req_valid` is low, `rsp_valid` is 0 and the other response outputs hold their values.
- R11: The refill way is a 2-bit counter that resets to 0 and increments on every `refill_req`, so the first refill uses way 1. On the same edge, `refill_ring` captures bits [5:4] of `refill_pte`.
- R12: Every response carries `rsp_pte_addr` = (`pte_base` | vaddr >> 10) with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_ring | input | 2 | Current privilege ring |
| pte_base | input | 32 | Page-table virtual base |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way to write |
| wr_index | input | 4 | Entry within the way |
| wr_vpn | input | 20 | Page tag (vaddr bits 31:12) |
| wr_ppn | input | 20 | Physical page (paddr bits 31:12) |
| wr_asid | input | 8 | Address-space identifier |
| wr_attr | input | 4 | Attribute code |
| rasid_we | input | 1 | Ring map write strobe |
| rasid_wdata | input | 32 | New ring map |
| refill_req | input | 1 | Advance refill way |
| refill_pte | input | 32 | Fetched page-table word |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_rights | output | 3 | Rights mask {X,W,R} |
| rsp_cache | output | 3 | Cache policy code |
| rsp_cause | output | 6 | Fault cause, 0 when allowed |
| rsp_pte_addr | output | 32 | Page-table-entry address |
| refill_way | output | 2 | Current refill way |
| refill_ring | output | 2 | Ring from the last refill word |

## Verification
Each kind of corrupted internal state shows at the ports in a specific way, always one cycle after the lookup that touches it:
- A corrupted entry or a wrong index slice turns an expected hit into a miss or a multi-hit.
- A wrong ring map byte, or a wrong lane priority, flips the privilege cause between allowed and faulting.
- A wrong attribute decode or side mask changes the rights and cache codes, and often the cause as well.

The refill counter shows a wrong state on the edge after each `refill_req`. The stimulus places entries in the small and large ways, uses identifiers on every ring, and includes an identifier absent from the ring map and a duplicated tag. It also rewrites the ring map and resets again, so every one of these faults becomes visible.

// File: rtl/tlb_ring_pkg.sv
package tlb_ring_pkg;

    localparam int VA_W     = 32;
    localparam int PAGE_MIN = 12;
    localparam int VPN_W    = VA_W - PAGE_MIN;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [5:0] CAUSE_NONE         = 6'd0;
    localparam logic [5:0] CAUSE_I_MISS       = 6'd16;
    localparam logic [5:0] CAUSE_I_MULTI      = 6'd17;
    localparam logic [5:0] CAUSE_I_PRIV       = 6'd18;
    localparam logic [5:0] CAUSE_I_PROHIB     = 6'd20;
    localparam logic [5:0] CAUSE_D_MISS       = 6'd24;
    localparam logic [5:0] CAUSE_D_MULTI      = 6'd25;
    localparam logic [5:0] CAUSE_D_PRIV       = 6'd26;
    localparam logic [5:0] CAUSE_LOAD_PROHIB  = 6'd28;
    localparam logic [5:0] CAUSE_STORE_PROHIB = 6'd29;

    localparam logic [2:0] CACHE_NONE    = 3'd0;
    localparam logic [2:0] CACHE_BYPASS  = 3'd1;
    localparam logic [2:0] CACHE_WB      = 3'd2;
    localparam logic [2:0] CACHE_WT      = 3'd3;
    localparam logic [2:0] CACHE_ISOLATE = 3'd4;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic [7:0]       asid;
        logic [3:0]       attr;
    } tlb_entry_t;

    // Page offset width of a way: the last way holds large pages.
    function automatic int way_shift(int w, int nways, int large_shift);
        return (w == nways - 1) ? large_shift : PAGE_MIN;
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_ring_pkg::*;
#(
    parameter  int NUM_WAYS    = 4,
    parameter  int WAY_ENTRIES = 16,
    parameter  int LARGE_SHIFT = 20,
    localparam int WAY_W       = $clog2(NUM_WAYS),
    localparam int IDX_W       = $clog2(WAY_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_index,
    input  tlb_entry_t       wr_entry,
    input  logic [VA_W-1:0]  lookup_vaddr,
    output tlb_entry_t       way_entry [NUM_WAYS]
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        localparam int SH = way_shift(w, NUM_WAYS, LARGE_SHIFT);
        tlb_entry_t slots [WAY_ENTRIES];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < WAY_ENTRIES; e++) begin
                    slots[e] <= '0;
                end
            end else if (wr_en && (wr_way == WAY_W'(w))) begin
                slots[wr_index] <= wr_entry;
            end
        end

        assign way_entry[w] = slots[lookup_vaddr[SH+IDX_W-1:SH]];
    end

endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
    import tlb_ring_pkg::*;
#(
    parameter int NUM_WAYS    = 4,
    parameter int LARGE_SHIFT = 20
) (
    input  logic [VA_W-1:0] vaddr,
    input  tlb_entry_t      way_entry [NUM_WAYS],
    input  logic [31:0]     ring_map,
    output logic            any_hit,
    output logic            multi_hit,
    output logic            ring_found,
    output logic [1:0]      entry_ring,
    output logic [3:0]      sel_attr,
    output logic [VA_W-1:0] sel_paddr
);

    logic [NUM_WAYS-1:0] hit;
    logic [VA_W-1:0]     off_mask [NUM_WAYS];
    logic [VPN_W-1:0]    sel_ppn;
    logic [7:0]          sel_asid;
    logic [VA_W-1:0]     sel_mask;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        localparam int SH = way_shift(w, NUM_WAYS, LARGE_SHIFT);
        localparam logic [VPN_W-1:0] TAG_MASK =
            ~((VPN_W'(1) << (SH - PAGE_MIN)) - VPN_W'(1));
        assign off_mask[w] = (VA_W'(1) << SH) - VA_W'(1);
        assign hit[w] = (((way_entry[w].vpn ^ vaddr[VA_W-1:PAGE_MIN]) & TAG_MASK) == '0)
                        && (way_entry[w].asid != 8'd0);
    end

    always_comb begin
        any_hit   = |hit;
        multi_hit = $countones(hit) > 1;
        sel_ppn   = '0;
        sel_asid  = '0;
        sel_attr  = '0;
        sel_mask  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit[w]) begin
                sel_ppn  = way_entry[w].ppn;
                sel_asid = way_entry[w].asid;
                sel_attr = way_entry[w].attr;
                sel_mask = off_mask[w];
            end
        end
        if (any_hit && !multi_hit) begin
            sel_paddr = ({sel_ppn, {PAGE_MIN{1'b0}}} & ~sel_mask) | (vaddr & sel_mask);
        end else begin
            sel_paddr = '0;
        end
        // Descending scan so the lowest matching lane wins.
        ring_found = 1'b0;
        entry_ring = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (ring_map[8*i +: 8] == sel_asid) begin
                ring_found = 1'b1;
                entry_ring = 2'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
    import tlb_ring_pkg::*;
(
    input  logic [3:0] attr,
    input  logic       is_fetch,
    output logic [2:0] rights,
    output logic [2:0] cache
);

    logic [2:0] raw;

    always_comb begin
        raw   = '0;
        cache = CACHE_NONE;
        if (attr < 4'd12) begin
            raw[RIGHT_R] = 1'b1;
            raw[RIGHT_W] = attr[1];
            raw[RIGHT_X] = attr[0];
            case (attr[3:2])
                2'd0:    cache = CACHE_BYPASS;
                2'd1:    cache = CACHE_WB;
                default: cache = CACHE_WT;
            endcase
        end else if (attr == 4'd13) begin
            raw[RIGHT_R] = 1'b1;
            raw[RIGHT_W] = 1'b1;
            cache        = CACHE_ISOLATE;
        end
        if (is_fetch) begin
            rights = raw & 3'b100;
        end else begin
            rights = raw & 3'b011;
        end
    end

endmodule

// File: rtl/tlb_ring_lookup.sv
module tlb_ring_lookup
    import tlb_ring_pkg::*;
#(
    parameter  int NUM_WAYS    = 4,
    parameter  int WAY_ENTRIES = 16,
    parameter  int LARGE_SHIFT = 20,
    localparam int WAY_W       = $clog2(NUM_WAYS),
    localparam int IDX_W       = $clog2(WAY_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       req_ring,
    input  logic [31:0]      pte_base,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [19:0]      wr_vpn,
    input  logic [19:0]      wr_ppn,
    input  logic [7:0]       wr_asid,
    input  logic [3:0]       wr_attr,
    input  logic             rasid_we,
    input  logic [31:0]      rasid_wdata,
    input  logic             refill_req,
    input  logic [31:0]      refill_pte,
    output logic             rsp_valid,
    output logic [31:0]      rsp_paddr,
    output logic [2:0]       rsp_rights,
    output logic [2:0]       rsp_cache,
    output logic [5:0]       rsp_cause,
    output logic [31:0]      rsp_pte_addr,
    output logic [1:0]       refill_way,
    output logic [1:0]       refill_ring
);

    localparam logic [31:0] RING_MAP_RESET = 32'h0403_0201;

    typedef struct packed {
        logic        valid;
        logic [31:0] paddr;
        logic [2:0]  rights;
        logic [2:0]  cache;
        logic [5:0]  cause;
        logic [31:0] pte_addr;
        logic [1:0]  refill_way;
        logic [1:0]  refill_ring;
        logic [31:0] ring_map;
    } state_t;

    localparam state_t STATE_RESET = '{
        valid: 1'b0, paddr: '0, rights: '0, cache: '0, cause: '0,
        pte_addr: '0, refill_way: '0, refill_ring: '0, ring_map: RING_MAP_RESET
    };

    state_t     st_d, st_q;
    tlb_entry_t wr_entry;
    tlb_entry_t way_entry [NUM_WAYS];
    logic       any_hit, multi_hit, ring_found;
    logic [1:0] entry_ring;
    logic [3:0] sel_attr;
    logic [31:0] sel_paddr;
    logic [2:0] dec_rights, dec_cache;
    logic       is_fetch;

    assign wr_entry = '{vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, attr: wr_attr};
    assign is_fetch = (req_kind == ACC_FETCH);

    tlb_entry_store #(
        .NUM_WAYS(NUM_WAYS), .WAY_ENTRIES(WAY_ENTRIES), .LARGE_SHIFT(LARGE_SHIFT)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_way(wr_way),
        .wr_index(wr_index), .wr_entry(wr_entry), .lookup_vaddr(req_vaddr),
        .way_entry(way_entry)
    );

    tlb_hit_select #(
        .NUM_WAYS(NUM_WAYS), .LARGE_SHIFT(LARGE_SHIFT)
    ) u_hit (
        .vaddr(req_vaddr), .way_entry(way_entry), .ring_map(st_q.ring_map),
        .any_hit(any_hit), .multi_hit(multi_hit), .ring_found(ring_found),
        .entry_ring(entry_ring), .sel_attr(sel_attr), .sel_paddr(sel_paddr)
    );

    tlb_attr_decode u_dec (
        .attr(sel_attr), .is_fetch(is_fetch), .rights(dec_rights), .cache(dec_cache)
    );

    always_comb begin
        logic granted;
        st_d  = st_q;
        granted = 1'b0;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.pte_addr = (pte_base | (req_vaddr >> 10)) & ~32'h3;
            st_d.paddr    = '0;
            st_d.rights   = '0;
            st_d.cache    = CACHE_NONE;
            st_d.cause    = CAUSE_NONE;
            if (!any_hit) begin
                st_d.cause = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
            end else if (multi_hit) begin
                st_d.cause = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
            end else begin
                st_d.paddr  = sel_paddr;
                st_d.rights = dec_rights;
                st_d.cache  = dec_cache;
                case (req_kind)
                    ACC_FETCH: granted = dec_rights[RIGHT_X];
                    ACC_WRITE: granted = dec_rights[RIGHT_W];
                    default:   granted = dec_rights[RIGHT_R];
                endcase
                if (!ring_found || (entry_ring < req_ring)) begin
                    st_d.cause = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
                end else if (!granted) begin
                    case (req_kind)
                        ACC_FETCH: st_d.cause = CAUSE_I_PROHIB;
                        ACC_WRITE: st_d.cause = CAUSE_STORE_PROHIB;
                        default:   st_d.cause = CAUSE_LOAD_PROHIB;
                    endcase
                end
            end
        end
        if (rasid_we) begin
            st_d.ring_map = rasid_wdata;
        end
        if (refill_req) begin
            st_d.refill_way  = st_q.refill_way + 2'd1;
            st_d.refill_ring = refill_pte[5:4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.valid;
    assign rsp_paddr    = st_q.paddr;
    assign rsp_rights   = st_q.rights;
    assign rsp_cache    = st_q.cache;
    assign rsp_cause    = st_q.cause;
    assign rsp_pte_addr = st_q.pte_addr;
    assign refill_way   = st_q.refill_way;
    assign refill_ring  = st_q.refill_ring;

endmodule

// File: rtl/tlb_ring_lookup_chk.sv
module tlb_ring_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        refill_req,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_rights,
    input logic [5:0]  rsp_cause,
    input logic [1:0]  refill_way
);

    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)));

    p_fetch_no_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == 2'd2) |-> (rsp_rights[1:0] == 2'b00));

    p_data_no_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) != 2'd2) |-> !rsp_rights[2]);

    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_cause == 6'd16 || rsp_cause == 6'd24))
            |-> (rsp_rights == 3'd0 && rsp_paddr == 32'd0));

    p_multi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_cause == 6'd17 || rsp_cause == 6'd25))
            |-> (rsp_rights == 3'd0 && rsp_paddr == 32'd0));

    p_grant_has_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == 6'd0)
            |-> (($past(req_kind) == 2'd2) ? rsp_rights[2] :
                 ($past(req_kind) == 2'd1) ? rsp_rights[1] : rsp_rights[0]));

    p_refill_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> (refill_way == $past(refill_way) + 2'd1));

endmodule

bind tlb_ring_lookup tlb_ring_lookup_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .refill_req(refill_req), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_rights(rsp_rights), .rsp_cause(rsp_cause), .refill_way(refill_way)
);

// File: tb/sim_tlb_ring_lookup.sv
`timescale 1ns/1ps
module sim_tlb_ring_lookup;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [1:0]  req_ring;
    logic [31:0] pte_base;
    logic        wr_en;
    logic [1:0]  wr_way;
    logic [3:0]  wr_index;
    logic [19:0] wr_vpn, wr_ppn;
    logic [7:0]  wr_asid;
    logic [3:0]  wr_attr;
    logic        rasid_we;
    logic [31:0] rasid_wdata;
    logic        refill_req;
    logic [31:0] refill_pte;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_rights, rsp_cache;
    logic [5:0]  rsp_cause;
    logic [31:0] rsp_pte_addr;
    logic [1:0]  refill_way, refill_ring;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_ring_lookup u0 (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic [1:0]  ring;
        logic [5:0]  cause;
        logic [31:0] pa;
        logic [2:0]  rights;
        logic [2:0]  cache;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_5123, 2'd0, 2'd0, 6'd0,  32'h8000_5123, 3'd3, 3'd1}, // R6 R9 bypass RWX data
        '{32'h0000_5123, 2'd2, 2'd0, 6'd0,  32'h8000_5123, 3'd4, 3'd1}, // R7 fetch keeps X only
        '{32'h0000_5ffc, 2'd1, 2'd1, 6'd26, 32'h8000_5ffc, 3'd3, 3'd1}, // R5 ring0 < ring1
        '{32'h1234_7abc, 2'd0, 2'd1, 6'd0,  32'h0004_2abc, 3'd1, 3'd2}, // R4 asid2 -> ring1
        '{32'h1234_7abc, 2'd1, 2'd0, 6'd29, 32'h0004_2abc, 3'd1, 3'd2}, // R8 store prohibited
        '{32'h1234_7abc, 2'd2, 2'd0, 6'd20, 32'h0004_2abc, 3'd0, 3'd2}, // R8 fetch prohibited
        '{32'h0534_5678, 2'd0, 2'd3, 6'd0,  32'hABC4_5678, 3'd3, 3'd4}, // R9 large way, R6 isolate
        '{32'h0534_5678, 2'd2, 2'd2, 6'd20, 32'hABC4_5678, 3'd0, 3'd4}, // R7 isolate fetch
        '{32'h0000_9000, 2'd0, 2'd0, 6'd25, 32'h0,         3'd0, 3'd0}, // R3 data multi-hit
        '{32'h0000_9000, 2'd2, 2'd0, 6'd17, 32'h0,         3'd0, 3'd0}, // R3 fetch multi-hit
        '{32'h0000_b000, 2'd0, 2'd0, 6'd26, 32'h0000_b000, 3'd3, 3'd1}, // R5 asid not in map
        '{32'h0000_c010, 2'd0, 2'd0, 6'd28, 32'h0000_c010, 3'd0, 3'd0}, // R6 attr 15, R8 load
        '{32'h0000_6000, 2'd0, 2'd0, 6'd24, 32'h0,         3'd0, 3'd0}, // R2 data miss
        '{32'h0000_6000, 2'd2, 2'd0, 6'd16, 32'h0,         3'd0, 3'd0}, // R2 fetch miss
        '{32'h0000_d004, 2'd2, 2'd0, 6'd0,  32'h3000_d004, 3'd4, 3'd3}, // R6 write-through
        '{32'h0000_d004, 2'd1, 2'd0, 6'd29, 32'h3000_d004, 3'd1, 3'd3}, // R8 no write right
        '{32'h1234_8abc, 2'd0, 2'd0, 6'd24, 32'h0,         3'd0, 3'd0}, // R1 empty index
        '{32'h1334_7abc, 2'd0, 2'd0, 6'd24, 32'h0,         3'd0, 3'd0}  // R1 tag mismatch
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [3:0] idx, input logic [19:0] vpn,
                      input logic [19:0] ppn, input logic [7:0] asid, input logic [3:0] attr);
        wr_en = 1'b1; wr_way = w; wr_index = idx; wr_vpn = vpn;
        wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] k, input logic [1:0] r);
        req_valid = 1'b1; req_vaddr = va; req_kind = k; req_ring = r;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        req_valid = 0; req_vaddr = 0; req_kind = 0; req_ring = 0;
        pte_base = 32'h8000_0000; wr_en = 0; wr_way = 0; wr_index = 0;
        wr_vpn = 0; wr_ppn = 0; wr_asid = 0; wr_attr = 0;
        rasid_we = 0; rasid_wdata = 0; refill_req = 0; refill_pte = 0;
        @(negedge clk);
        do_reset();

        // Reset state (R10, R11)
        chk("R10 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 reset cause", 32'(rsp_cause), 32'd0);
        chk("R11 reset refill_way", 32'(refill_way), 32'd0);
        // R1: empty table misses after reset
        look(32'h0000_5123, 2'd0, 2'd0);
        chk("R1 miss after reset", 32'(rsp_cause), 32'd24);

        wr(2'd0, 4'd5,  20'h00005, 20'h80005, 8'h01, 4'd3);
        wr(2'd1, 4'd7,  20'h12347, 20'h00042, 8'h02, 4'd4);
        wr(2'd3, 4'd3,  20'h05300, 20'hABC00, 8'h04, 4'd13);
        wr(2'd0, 4'd9,  20'h00009, 20'h11111, 8'h01, 4'd0);
        wr(2'd2, 4'd9,  20'h00009, 20'h22222, 8'h03, 4'd0);
        wr(2'd1, 4'd11, 20'h0000b, 20'h0000b, 8'h77, 4'd3);
        wr(2'd2, 4'd12, 20'h0000c, 20'h0000c, 8'h01, 4'd15);
        wr(2'd0, 4'd13, 20'h0000d, 20'h3000d, 8'h01, 4'd9);

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].va, VECS[i].kind, VECS[i].ring);
            chk($sformatf("vec%0d R10 valid", i), 32'(rsp_valid), 32'd1);
            chk($sformatf("vec%0d R2/R3/R5/R8 cause", i), 32'(rsp_cause), 32'(VECS[i].cause));
            chk($sformatf("vec%0d R9 paddr", i), rsp_paddr, VECS[i].pa);
            chk($sformatf("vec%0d R6/R7 rights", i), 32'(rsp_rights), 32'(VECS[i].rights));
            chk($sformatf("vec%0d R6 cache", i), 32'(rsp_cache), 32'(VECS[i].cache));
            chk($sformatf("vec%0d R12 pte_addr", i), rsp_pte_addr,
                (32'h8000_0000 | (VECS[i].va >> 10)) & 32'hFFFF_FFFC);
        end

        // R10: outputs hold while idle
        look(32'h0000_5123, 2'd0, 2'd0);
        req_vaddr = 32'h0000_6000;
        @(negedge clk);
        chk("R10 idle valid low", 32'(rsp_valid), 32'd0);
        chk("R10 idle paddr held", rsp_paddr, 32'h8000_5123);
        chk("R10 idle cause held", 32'(rsp_cause), 32'd0);

        // R4: ring map rewrite (asid1 -> ring3, asid4 -> ring0)
        rasid_we = 1'b1; rasid_wdata = 32'h0102_0304;
        @(negedge clk);
        rasid_we = 1'b0;
        look(32'h0000_5123, 2'd0, 2'd2);
        chk("R4 asid1 now ring3", 32'(rsp_cause), 32'd0);
        look(32'h0534_5678, 2'd0, 2'd1);
        chk("R4 asid4 now ring0", 32'(rsp_cause), 32'd26);

        // R11: refill counter sequence and ring field
        refill_pte = 32'h0000_0030;
        for (int k = 1; k <= 5; k++) begin
            refill_req = 1'b1;
            @(negedge clk);
            chk($sformatf("R11 refill way step %0d", k), 32'(refill_way), 32'(k % 4));
        end
        refill_req = 1'b0;
        chk("R11 refill ring", 32'(refill_ring), 32'd3);

        // R1 R4: reset clears entries and restores ring map
        do_reset();
        look(32'h1234_7abc, 2'd0, 2'd0);
        chk("R1 entries cleared by reset", 32'(rsp_cause), 32'd24);
        wr(2'd0, 4'd5, 20'h00005, 20'h80005, 8'h01, 4'd3);
        look(32'h0000_5123, 2'd0, 2'd1);
        chk("R4 ring map reset value", 32'(rsp_cause), 32'd26);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule